// File: doc/BRIEF.md
# Wake Frame Sequence Detector

This block sits beside a receive path and looks for a wake frame in the bytes the MAC has accepted. A wake frame carries, in its data field, a run of back-to-back copies of the station's own address. Byte zero of a frame is marked with a start flag and the last byte with an end flag. The block counts byte positions, checks the destination address, and tracks the run of address copies. When the frame ends it decides whether the run finished early enough to leave room for the trailing frame check sequence. If so, and the block is in wake mode, it raises a one-cycle wake pulse.

Wake mode is a level held in a register. It is entered when the mode select is set and either power-good is low or the software enable is high. While the mode is active, the block asks the receive path to drop every frame and blocks transmit and bus-master activity. The byte input is a valid/ready stream whose ready is always high. The block never applies back-pressure. A beat is taken on every cycle that valid is high, and nothing on the other input pins counts while valid is low.

Top module: `mp_wake_detect`

## Requirements
- R1: `mode_active` is low after reset. One cycle after a clock edge that samples `mode_sel`=1 with (`power_good`=0 or `sw_enable`=1), it is 1. One cycle after an edge where that condition is false, it is 0.
- R2: `rx_flush` and `tx_inhibit` are 1 exactly when `mode_active` is 1.
- R3: `rx_ready` is always 1. A byte is taken only on an edge with `rx_valid`=1. While `rx_valid`=0, the values on `rx_data`, `rx_sof` and `rx_eof` have no effect.
- R4: A taken byte with `rx_sof`=1 is frame byte 0. Each following taken byte advances the index by one. Only bytes at index `HDR_BYTES` (14) or higher can belong to the address run.
- R5: A run is `COPIES` copies in a row of the station address, `ADDR_BYTES` bytes per copy. Byte k of a copy must equal `station_addr[8*(ADDR_BYTES-1-k) +: 8]`, so the most significant byte comes first.
- R6: Any byte that differs from the expected byte, even in one bit, ends the current run. That same byte is then tested as the first byte of a new run.
- R7: Let C be the number of frame bytes up to and including the byte that completes the run. Let L be the frame length, counted at the `rx_eof` byte. A frame can only wake when C + `FCS_BYTES` (4) <= L.
- R8: With `any_dest`=0, frame bytes 0..`ADDR_BYTES`-1 must equal the station address in the R5 order. With `any_dest`=1, any destination is accepted, including broadcast and other unicast addresses.
- R9: `wake_pulse` is high for exactly the one cycle after the `rx_eof` byte is taken. It is high only if the frame met R5 to R8 and `mode_active` was 1 at that edge.
- R10: After reset, `wake_pulse`, `mode_active`, `rx_flush` and `tx_inhibit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_ready | output | 1 | Always 1, no back-pressure |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Beat is frame byte 0 |
| rx_eof | input | 1 | Beat is the last frame byte |
| station_addr | input | 8*ADDR_BYTES | Station address, first byte in the top bits |
| any_dest | input | 1 | 1: accept any destination address |
| mode_sel | input | 1 | Wake mode selected |
| sw_enable | input | 1 | Software entry into wake mode |
| power_good | input | 1 | Low requests wake mode |
| mode_active | output | 1 | Wake mode is active |
| rx_flush | output | 1 | Drop all received frames |
| tx_inhibit | output | 1 | Block transmit and bus-master activity |
| wake_pulse | output | 1 | One-cycle wake detection |

## Verification
The bench builds the block with `COPIES`=3 and `IDX_W`=7. It keeps the 6-byte address, the 14-byte header offset and the 4-byte check field. This shrinks the run to 18 bytes, so frames of about 50 bytes are enough to sweep every start position across the header boundary and every frame length across the check-field limit. It also makes it cheap to corrupt each run byte in turn. The configuration still covers every combination of the three mode inputs, all destination cases, and restarts after a partial run.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] mp_byte_t;

  typedef struct packed {
    logic     sof;
    logic     eof;
    mp_byte_t data;
  } mp_beat_t;
endpackage

// File: rtl/mp_mode_ctrl.sv
module mp_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic sw_enable,
  input  logic power_good,
  output logic active
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= mode_sel & (~power_good | sw_enable);
  end

  assign active = active_q;

  // R1: hardware entry when power-good drops
  p_mode_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !power_good) |=> active);
  // R1: exit when power-good returns and software enable is clear
  p_mode_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (power_good && !sw_enable) |=> !active);
endmodule

// File: rtl/mp_dest_check.sv
module mp_dest_check
  import mp_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  mp_beat_t       beat,
  input  logic [IDX_W-1:0] cur_idx,
  input  mp_byte_t       addr_b [ADDR_BYTES],
  output logic           match_now
);
  logic match_q;
  logic base;
  logic byte_ok;

  always_comb begin
    base    = beat.sof ? 1'b1 : match_q;
    byte_ok = 1'b1;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cur_idx == IDX_W'(i) && beat.data != addr_b[i]) byte_ok = 1'b0;
    end
    match_now = base & byte_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    match_q <= 1'b1;
    else if (take) match_q <= match_now;
  end

  // R8: once the destination field is past, the verdict only changes at a new frame
  p_dest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !beat.sof && cur_idx >= IDX_W'(ADDR_BYTES) && !match_q) |=> !match_q);
endmodule

// File: rtl/mp_seq_scan.sv
module mp_seq_scan
  import mp_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16,
  parameter int HDR_BYTES  = 14,
  parameter int IDX_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  mp_beat_t         beat,
  input  logic [IDX_W-1:0] cur_idx,
  input  mp_byte_t         addr_b [ADDR_BYTES],
  output logic             hit,
  output logic [IDX_W-1:0] hit_at
);
  localparam int POS_W = $clog2(ADDR_BYTES);
  localparam int CNT_W = $clog2(COPIES + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(ADDR_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_b, pos_n;
  logic [CNT_W-1:0] cnt_q, cnt_b, cnt_n;
  logic             found_q, found_b, found_n;
  logic [IDX_W-1:0] at_q, at_n;
  logic             in_data;

  always_comb begin
    pos_b   = beat.sof ? '0   : pos_q;
    cnt_b   = beat.sof ? '0   : cnt_q;
    found_b = beat.sof ? 1'b0 : found_q;
    pos_n   = pos_b;
    cnt_n   = cnt_b;
    found_n = found_b;
    at_n    = at_q;
    in_data = cur_idx >= IDX_W'(HDR_BYTES);
    if (in_data && !found_b) begin
      if (beat.data == addr_b[pos_b]) begin
        if (pos_b == POS_LAST) begin
          pos_n = '0;
          cnt_n = cnt_b + 1'b1;
          if (cnt_b == CNT_W'(COPIES - 1)) begin
            found_n = 1'b1;
            at_n    = cur_idx + 1'b1;
          end
        end else begin
          pos_n = pos_b + 1'b1;
        end
      end else if (beat.data == addr_b[0]) begin
        pos_n = POS_W'(1);
        cnt_n = '0;
      end else begin
        pos_n = '0;
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      cnt_q   <= '0;
      found_q <= 1'b0;
      at_q    <= '0;
    end else if (take) begin
      pos_q   <= pos_n;
      cnt_q   <= cnt_n;
      found_q <= found_n;
      at_q    <= at_n;
    end
  end

  assign hit    = found_n;
  assign hit_at = at_n;

  // R6: run position always inside one address copy
  p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);
  // R5: never more copies than required
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(COPIES));
  // R4: header bytes never advance the copy count
  p_hdr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_idx < IDX_W'(HDR_BYTES)) |=> (cnt_q == '0 && !found_q));
endmodule

// File: rtl/mp_wake_detect.sv
module mp_wake_detect
  import mp_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int COPIES     = 16,
  parameter int HDR_BYTES  = 14,
  parameter int FCS_BYTES  = 4,
  parameter int IDX_W      = 11,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              any_dest,
  input  logic              mode_sel,
  input  logic              sw_enable,
  input  logic              power_good,
  output logic              mode_active,
  output logic              rx_flush,
  output logic              tx_inhibit,
  output logic              wake_pulse
);
  mp_byte_t         addr_b [ADDR_BYTES];
  mp_beat_t         beat;
  logic             take;
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             dest_now, hit;
  logic [IDX_W-1:0] hit_at;
  logic [IDX_W:0]   frame_len, need_len;
  logic             wake_q, wake_n;
  logic             active;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign rx_ready = 1'b1;
  assign take     = rx_valid;
  assign beat     = '{sof: rx_sof, eof: rx_eof, data: rx_data};
  assign cur_idx  = rx_sof ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (take && cur_idx != '1) idx_q <= cur_idx + 1'b1;
  end

  mp_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_enable(sw_enable),
    .power_good(power_good), .active(active)
  );

  mp_dest_check #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_dest (
    .clk(clk), .rst_n(rst_n), .take(take), .beat(beat), .cur_idx(cur_idx),
    .addr_b(addr_b), .match_now(dest_now)
  );

  mp_seq_scan #(.ADDR_BYTES(ADDR_BYTES), .COPIES(COPIES), .HDR_BYTES(HDR_BYTES),
                .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .take(take), .beat(beat), .cur_idx(cur_idx),
    .addr_b(addr_b), .hit(hit), .hit_at(hit_at)
  );

  always_comb begin
    frame_len = {1'b0, cur_idx} + 1'b1;
    need_len  = {1'b0, hit_at} + (IDX_W+1)'(FCS_BYTES);
    wake_n    = take && rx_eof && active && hit && (any_dest || dest_now) &&
                (need_len <= frame_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_n;
  end

  assign mode_active = active;
  assign rx_flush    = active;
  assign tx_inhibit  = active;
  assign wake_pulse  = wake_q;

  // R9: pulse lasts one cycle
  p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R9: pulse only while mode was active
  p_wake_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(mode_active));
  // R7: pulse follows an end-of-frame beat
  p_wake_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(rx_valid && rx_eof));
  // R3: never back-pressure
  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n) rx_ready);
endmodule

// File: tb/sim_mp_wake_detect.sv
module sim_mp_wake_detect;
  localparam int AB = 6, CP = 3, HDR = 14, FCS = 4, IW = 7;
  localparam int RUN = AB * CP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic any_dest = 1'b0, mode_sel = 1'b0, sw_enable = 1'b0, power_good = 1'b1;
  logic rx_ready, mode_active, rx_flush, tx_inhibit, wake_pulse;

  int n_chk = 0, n_fail = 0;
  logic [7:0] fr [0:127];
  bit done = 0;

  always #2.5 clk = ~clk;

  mp_wake_detect #(.ADDR_BYTES(AB), .COPIES(CP), .HDR_BYTES(HDR), .FCS_BYTES(FCS),
                   .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .station_addr(station_addr),
    .any_dest(any_dest), .mode_sel(mode_sel), .sw_enable(sw_enable),
    .power_good(power_good), .mode_active(mode_active), .rx_flush(rx_flush),
    .tx_inhibit(tx_inhibit), .wake_pulse(wake_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] abyte(input int k);
    return station_addr[8*(AB-1-k) +: 8];
  endfunction

  // dtype: 0 station, 1 broadcast, 2 other unicast; s<0 puts no run
  task automatic build(input int len, input int s, input int dtype);
    for (int i = 0; i < 128; i++) fr[i] = 8'hA5;
    for (int i = 0; i < AB; i++)
      fr[i] = (dtype == 1) ? 8'hFF : (dtype == 2 && i == AB-1) ? 8'h56 : abyte(i);
    for (int i = AB; i < 12; i++) fr[i] = 8'h0A + 8'(i);
    fr[12] = 8'h08; fr[13] = 8'h00;
    if (s >= 0) for (int i = 0; i < RUN; i++) fr[s+i] = abyte(i % AB);
    if (len < 1) $display("bad length");
  endtask

  function automatic bit model(input int len, input int dtype, input bit act);
    bit ok;
    if (!act) return 0;
    if (!any_dest && dtype != 0) return 0;
    for (int s = HDR; s + RUN + FCS <= len; s++) begin
      ok = 1;
      for (int i = 0; i < RUN; i++) if (fr[s+i] != abyte(i % AB)) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic send(input int len, input bit gaps, input bit exp, input string req);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        rx_valid = 0; rx_sof = 1; rx_eof = 1; rx_data = abyte(0);
      end
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i]; rx_sof = (i == 0); rx_eof = (i == len-1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    check(wake_pulse == exp, req, wake_pulse, exp);
    @(negedge clk);
    check(wake_pulse == 0, "R9 pulse single cycle", wake_pulse, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit e;
    repeat (3) @(negedge clk);
    check(wake_pulse == 0 && mode_active == 0, "R10 reset outputs", wake_pulse, 0);
    check(rx_flush == 0 && tx_inhibit == 0, "R10 reset flush/inhibit", rx_flush, 0);
    check(rx_ready == 1, "R3 ready high", rx_ready, 1);
    rst_n = 1;

    // R1 R2: all mode input combinations
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      mode_sel = m[0]; power_good = m[1]; sw_enable = m[2];
      @(negedge clk);
      e = m[0] & (~m[1] | m[2]);
      check(mode_active == e, "R1 mode level", mode_active, e);
      check(rx_flush == e && tx_inhibit == e, "R2 flush/inhibit", rx_flush, e);
    end

    @(negedge clk); mode_sel = 1; power_good = 0; sw_enable = 0;
    @(negedge clk);

    // R4 R7: start position sweep with fixed length
    for (int s = 8; s <= 34; s++) begin
      build(56, s, 0);
      send(56, 0, model(56, 0, 1), (s < HDR) ? "R4 header start" : "R7 start sweep");
    end
    // R7: length sweep around the check-field limit
    for (int l = 30; l <= 40; l++) begin
      build(l, 14, 0);
      e = (HDR + RUN + FCS <= l);
      send(l, 0, e, "R7 length sweep");
    end
    // R5 R6: single-bit corruption of each run byte
    for (int b = 0; b < RUN; b++) begin
      build(60, 20, 0);
      fr[20+b] = fr[20+b] ^ (8'h01 << (b % 8));
      send(60, 0, 0, "R6 one-bit mismatch");
    end
    // R5: exact run in a frame
    build(60, 20, 0);
    send(60, 0, 1, "R5 full run");
    // R6: partial run restarted on the breaking byte
    for (int p = 1; p < AB; p++) begin
      build(64, 20, 0);
      for (int i = 0; i < p; i++) fr[20-p+i] = abyte(i);
      send(64, 0, 1, "R6 restart after partial");
    end
    // R6: mismatch byte equal to address byte 0 starts a run
    build(64, 25, 0);
    fr[20] = abyte(0); fr[21] = abyte(1); fr[22] = abyte(2); fr[23] = abyte(0);
    fr[24] = 8'hA5;
    send(64, 0, 1, "R6 overlap");
    // R8: destination modes
    for (int a = 0; a < 2; a++) begin
      for (int d = 0; d < 3; d++) begin
        @(negedge clk); any_dest = a[0];
        build(60, 20, d);
        e = model(60, d, 1);
        send(60, 0, e, "R8 destination mode");
      end
    end
    any_dest = 0;
    // R3: idle beats with garbage are ignored
    build(60, 20, 0);
    send(60, 1, 1, "R3 valid gaps ignored");
    // R9: no wake when mode inactive
    @(negedge clk); power_good = 1;
    @(negedge clk);
    check(mode_active == 0, "R1 exit on power-good", mode_active, 0);
    build(60, 20, 0);
    send(60, 0, 0, "R9 inactive mode");
    // R1: software entry
    @(negedge clk); sw_enable = 1;
    @(negedge clk);
    check(mode_active == 1, "R1 software entry", mode_active, 1);
    build(60, 20, 0);
    send(60, 0, 1, "R9 software mode wake");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule